// File: doc/BRIEF.md
# Packed-Pixel Rectangle Fill Engine

This block paints a solid-coloured rectangle into video memory while the host processor carries on with other work. The host presents a rectangle (left pixel, top row, width, height), a 4-bit colour, the row stride of the frame in bytes and the byte address of the frame origin, then pulses a start input. The engine reports that it is running on `busy`. It then walks the rectangle row by row and issues one byte-wide memory access at a time through a request/acknowledge port. When the last byte is written it pulses `done`.

Pixels are 4 bits wide and two share each byte, so a rectangle can begin or end in the middle of a byte. For such an edge byte the engine reads the byte first and rewrites it with only the rectangle's nibble changed. Every other byte is written blind, with the colour in both halves. Memory arbitration and display refresh sit outside this block.

Top module: `rectFillEngine`

## Requirements
- R1: After reset `busy`, `done` and `memReq` are all low.
- R2: A `start` pulse seen while idle makes `busy` high from the next clock edge, and it stays high until the cycle in which `done` is high.
- R3: Pixel (x, y) lives in the byte at `baseAddr + y*pitch + floor(x/2)`. An even x uses bits [3:0] and an odd x uses bits [7:4]. After a fill, every pixel inside the rectangle holds `colour` and every other nibble of memory is unchanged.
- R4: A byte fully covered by the rectangle is written once, with `colour` in both nibbles, and is never read. Each row costs exactly one write for each byte it touches.
- R5: When a row starts on an odd x, or ends on an even x, the byte at that edge is read once and then written back with its other nibble preserved. No other byte is read.
- R6: Once `memReq` is raised it stays high, and `memAddr`, `memWe` and `memWdata` stay stable, until a clock edge samples `memAck` high. `memWe` high marks a write and low marks a read, and for a read `memRdata` is taken on the acknowledged edge.
- R7: `done` is high for exactly one cycle when a fill finishes, and `busy` is low on the following cycle.
- R8: A width or height of zero gives a `done` pulse with no memory access at all.
- R9: A `start` pulse while `busy` is high is ignored: the running fill and its final memory contents are unaffected, and no second `done` follows.
- R10: A one-pixel-wide rectangle changes only the single nibble in each row that is selected by the parity of x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fill with the present parameters (idle only) |
| xPos | input | CW | Left pixel column |
| yPos | input | CW | Top row |
| width | input | CW | Rectangle width in pixels |
| height | input | CW | Rectangle height in rows |
| colour | input | 4 | Fill colour |
| pitch | input | AW | Bytes from one row to the next |
| baseAddr | input | AW | Byte address of pixel (0,0) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Byte address of the access |
| memWdata | output | 8 | Write data |
| memAck | input | 1 | Access accepted on this edge |
| memRdata | input | 8 | Read data, valid with `memAck` |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The fill is tried with random rectangles whose left and right edges fall on every mix of even and odd columns, so fully packed rows can be told apart from rows that need a read at one edge, at both edges or at neither. Directed cases cover one-pixel-wide columns at even and odd x, which separate the two nibble positions, and zero width and zero height, which must produce no access. A second start issued in the middle of a fill, with a different colour, shows whether a busy engine lets new parameters leak into a running job. The memory model acknowledges after random delays, and the whole memory image is compared with a bench-side model, so stray writes outside the rectangle are caught along with wrong access counts.

// File: rtl/rfPkg.sv
package rfPkg;
  typedef struct packed {
    logic load;
    logic capRd;
    logic advByte;
    logic advRow;
  } rfStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_RD, ST_WR, ST_FIN
  } rfStateT;
endpackage

// File: rtl/rfDatapath.sv
module rfDatapath
  import rfPkg::*;
#(
  parameter int AW = 21,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  rfStrobeT      ctl,
  input  logic [CW-1:0] xPos,
  input  logic [CW-1:0] yPos,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  input  logic [3:0]    colour,
  input  logic [AW-1:0] pitch,
  input  logic [AW-1:0] baseAddr,
  input  logic [7:0]    memRdata,
  output logic [AW-1:0] curAddr,
  output logic [7:0]    wdata,
  output logic          needRmw,
  output logic          lastByte,
  output logic          lastRow,
  output logic          zeroSize
);
  localparam int NW = CW + 1;

  logic [NW-1:0] xEnd, spanBytes, nBytesR, byteIdx;
  logic [AW-1:0] startAddr, rowAddr, pitchR;
  logic [CW-1:0] rowsLeft;
  logic [3:0]    colourR;
  logic [7:0]    rdData;
  logic          leftPart, rightPart, isFirst;

  assign xEnd      = NW'(xPos) + NW'(width) - NW'(1);
  assign spanBytes = (xEnd >> 1) - (NW'(xPos) >> 1) + NW'(1);
  assign startAddr = baseAddr + AW'(yPos) * pitch + AW'(xPos >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      rowAddr   <= '0;
      pitchR    <= '0;
      nBytesR   <= '0;
      byteIdx   <= '0;
      rowsLeft  <= '0;
      colourR   <= '0;
      rdData    <= '0;
      leftPart  <= 1'b0;
      rightPart <= 1'b0;
      zeroSize  <= 1'b0;
    end else if (ctl.load) begin
      curAddr   <= startAddr;
      rowAddr   <= startAddr;
      pitchR    <= pitch;
      nBytesR   <= spanBytes;
      byteIdx   <= '0;
      rowsLeft  <= height;
      colourR   <= colour;
      leftPart  <= xPos[0];
      rightPart <= ~xEnd[0];
      zeroSize  <= (width == '0) || (height == '0);
    end else begin
      if (ctl.capRd) rdData <= memRdata;
      if (ctl.advByte) begin
        curAddr <= curAddr + AW'(1);
        byteIdx <= byteIdx + NW'(1);
      end
      if (ctl.advRow) begin
        rowAddr  <= rowAddr + pitchR;
        curAddr  <= rowAddr + pitchR;
        byteIdx  <= '0;
        rowsLeft <= rowsLeft - CW'(1);
      end
    end
  end

  assign isFirst  = (byteIdx == '0);
  assign lastByte = (byteIdx == nBytesR - NW'(1));
  assign lastRow  = (rowsLeft == CW'(1));
  assign needRmw  = (isFirst && leftPart) || (lastByte && rightPart);

  always_comb begin
    if (isFirst && leftPart)
      wdata = {colourR, rdData[3:0]};
    else if (lastByte && rightPart)
      wdata = {rdData[7:4], colourR};
    else
      wdata = {colourR, colourR};
  end

  // R5
  cap_only_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capRd |-> needRmw);
  // R4
  adv_not_past_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advByte |-> !lastByte);
endmodule

// File: rtl/rfControl.sv
module rfControl
  import rfPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     memAck,
  input  logic     needRmw,
  input  logic     lastByte,
  input  logic     lastRow,
  input  logic     zeroSize,
  output rfStrobeT ctl,
  output logic     memReq,
  output logic     memWe,
  output logic     busy,
  output logic     done
);
  rfStateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.load  = 1'b1;
        nextState = ST_PREP;
      end
      ST_PREP: begin
        if (zeroSize)     nextState = ST_FIN;
        else if (needRmw) nextState = ST_RD;
        else              nextState = ST_WR;
      end
      ST_RD: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.capRd = 1'b1;
          nextState = ST_WR;
        end
      end
      ST_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (!lastByte) begin
            ctl.advByte = 1'b1;
            nextState   = ST_PREP;
          end else if (lastRow) begin
            nextState = ST_FIN;
          end else begin
            ctl.advRow = 1'b1;
            nextState  = ST_PREP;
          end
        end
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  // R8
  zero_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PREP && zeroSize) |=> done && !memReq);
  // R5
  read_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> needRmw);
endmodule

// File: rtl/rectFillEngine.sv
module rectFillEngine
  import rfPkg::*;
#(
  parameter int AW = 21,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] xPos,
  input  logic [CW-1:0] yPos,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  input  logic [3:0]    colour,
  input  logic [AW-1:0] pitch,
  input  logic [AW-1:0] baseAddr,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  input  logic          memAck,
  input  logic [7:0]    memRdata,
  output logic          busy,
  output logic          done
);
  rfStrobeT ctl;
  logic needRmw, lastByte, lastRow, zeroSize;

  rfControl ctrl_i (
    .clk, .rstN, .start, .memAck,
    .needRmw, .lastByte, .lastRow, .zeroSize,
    .ctl, .memReq, .memWe, .busy, .done
  );

  rfDatapath #(.AW(AW), .CW(CW)) dp_i (
    .clk, .rstN, .ctl,
    .xPos, .yPos, .width, .height, .colour, .pitch, .baseAddr,
    .memRdata,
    .curAddr(memAddr), .wdata(memWdata),
    .needRmw, .lastByte, .lastRow, .zeroSize
  );

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq && $stable(memAddr) && $stable(memWe)
                            && $stable(memWdata));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !done);
endmodule

// File: tb/rectFillEngine_tb.sv
module rectFillEngine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int CW = 8;
  localparam int MEMSZ = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [CW-1:0] xPos = '0, yPos = '0, width = '0, height = '0;
  logic [3:0] colour = '0;
  logic [AW-1:0] pitch = '0, baseAddr = '0;
  logic memReq, memWe, memAck = 1'b0, busy, done;
  logic [AW-1:0] memAddr;
  logic [7:0] memWdata, memRdata = '0;

  logic [7:0] mem [MEMSZ];
  logic [7:0] refMem [MEMSZ];
  int wrCnt = 0, rdCnt = 0, dly = 0;
  int nChecks = 0, nFails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rectFillEngine #(.AW(AW), .CW(CW)) dut_i (
    .clk, .rstN, .start, .xPos, .yPos, .width, .height, .colour, .pitch,
    .baseAddr, .memReq, .memWe, .memAddr, .memWdata, .memAck, .memRdata,
    .busy, .done
  );

  // memory model: acknowledges after a random delay, acts on the falling edge
  always @(negedge clk) begin
    if (memAck) memAck <= 1'b0;
    else if (memReq) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        memAck <= 1'b1;
        if (memWe) begin
          mem[memAddr] <= memWdata;
          wrCnt <= wrCnt + 1;
        end else begin
          memRdata <= mem[memAddr];
          rdCnt <= rdCnt + 1;
        end
        dly <= int'($urandom_range(0, 2));
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 180000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: actual cycles=%0d expected < 180000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expWrites(int x, int w, int h);
    if (w == 0 || h == 0) return 0;
    return h * (((x + w - 1) / 2) - (x / 2) + 1);
  endfunction

  function automatic int expReads(int x, int w, int h);
    if (w == 0 || h == 0) return 0;
    return h * ((x % 2) + (((x + w - 1) % 2 == 0) ? 1 : 0));
  endfunction

  task automatic refFill(int x, int y, int w, int h, int c, int p, int b);
    for (int r = 0; r < h; r++)
      for (int px = x; px < x + w; px++) begin
        int a = b + (y + r) * p + px / 2;
        if (px % 2 == 0) refMem[a][3:0] = 4'(c);
        else             refMem[a][7:4] = 4'(c);
      end
  endtask

  task automatic compareMem(string req);
    int bad = 0, firstA = -1;
    for (int a = 0; a < MEMSZ; a++)
      if (mem[a] !== refMem[a]) begin
        bad++;
        if (firstA < 0) firstA = a;
      end
    if (firstA >= 0)
      $display("  at byte %0d: actual %0h expected %0h", firstA, mem[firstA], refMem[firstA]);
    check(bad == 0, req, bad, 0);
  endtask

  // One fill; optionally a second start with other values while busy (R9)
  task automatic runFill(int x, int y, int w, int h, int c, int p, int b,
                         bit restart, string req);
    int w0 = wrCnt, r0 = rdCnt, t = 0, dones = 0;
    @(negedge clk);
    xPos = CW'(x); yPos = CW'(y); width = CW'(w); height = CW'(h);
    colour = 4'(c); pitch = AW'(p); baseAddr = AW'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    if (restart && !done) begin
      @(negedge clk);
      xPos = CW'(x ^ 1); colour = 4'(c ^ 5); width = CW'(w + 3); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && t < 30000) begin
      @(negedge clk);
      t++;
    end
    check(done === 1'b1, {req, " R7 done seen"}, int'(done), 1);
    @(negedge clk);
    check(!busy && !done, "R7 busy/done low after pulse", int'({busy, done}), 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 0 && !busy, "R9 no second completion", dones, 0);
    refFill(x, y, w, h, c, p, b);
    compareMem({req, " R3 memory image"});
    check(wrCnt - w0 == expWrites(x, w, h), {req, " R4 write count"},
          wrCnt - w0, expWrites(x, w, h));
    check(rdCnt - r0 == expReads(x, w, h), {req, " R5 read count"},
          rdCnt - r0, expReads(x, w, h));
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < MEMSZ; a++) begin
      mem[a] = 8'($urandom);
      refMem[a] = mem[a];
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !memReq, "R1 reset state", int'({busy, done, memReq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memReq, "R1 idle after reset", int'({busy, done, memReq}), 0);

    // directed edge parity cases
    runFill(4, 2, 8, 3, 4'hA, 80, 16, 1'b0, "R4 aligned both ends");
    runFill(5, 3, 8, 2, 4'h3, 80, 16, 1'b0, "R5 odd start even end");
    runFill(5, 6, 7, 2, 4'h6, 80, 16, 1'b0, "R5 odd start odd end");
    runFill(8, 9, 5, 2, 4'h9, 80, 16, 1'b0, "R5 even start even end");
    runFill(10, 12, 1, 4, 4'hC, 80, 16, 1'b0, "R10 single column even x");
    runFill(11, 12, 1, 4, 4'h2, 80, 16, 1'b0, "R10 single column odd x");
    runFill(20, 1, 0, 5, 4'hF, 80, 16, 1'b0, "R8 zero width");
    runFill(20, 1, 6, 0, 4'hF, 80, 16, 1'b0, "R8 zero height");
    runFill(3, 18, 20, 4, 4'h7, 88, 40, 1'b1, "R9 restart while busy");

    // random rectangles
    for (int n = 0; n < 24; n++) begin
      int x = int'($urandom_range(0, 100));
      int w = int'($urandom_range(1, 60));
      int h = int'($urandom_range(1, 12));
      int y = int'($urandom_range(0, 11));
      int p = int'($urandom_range(80, 96));
      int b = int'($urandom_range(0, 255));
      runFill(x, y, w, h, int'($urandom_range(0, 15)), p, b, 1'b0, "R3 random");
    end
    summary();
  end
endmodule